// File: doc/BRIEF.md
# Indirect Configuration-Register Sequencer

This block is the control sequencer of a reconfigurable datapath. It fetches one narrow instruction per clock cycle from a small instruction store. Each instruction does not carry control bits. It carries three 4-bit indices, one each into three banks of wide configuration registers: crossbar routing, memory access and processing unit. The three selected entries are driven out as control words for exactly the cycle in which that instruction executes. The datapath behind them is therefore fully reconfigured on every cycle.

Program flow covers sequential increment, unconditional jumps, jumps conditioned on one of several status flags, and a halt. A host starts and stops execution. While the sequencer is stopped, the host writes the instruction store and the three configuration banks through a single write port. While stopped, the control words are all zero.

Top module: `cfg_seq`

## Requirements
- R1: After reset `running` is 0 and all three control words are zero.
- R2: A `start` pulse without `stop` sets `running` and the program counter to address 0 at that edge. The configuration of instruction 0 appears on the control outputs in the cycle that follows.
- R3: While running, the control outputs are taken from the three banks, each indexed by its field of the current instruction. The instruction layout is: bits [3:0] crossbar index, [7:4] memory index, [11:8] processing-unit index, [17:12] jump target, [19:18] flag select, [21:20] opcode.
- R4: Opcode 0 advances the program counter by one. From address 63 it wraps to 0.
- R5: Opcode 1 loads the jump target into the program counter.
- R6: Opcode 2 jumps to the target when `flags[flag select]` is 1 and otherwise advances by one. Flags other than the selected one have no effect.
- R7: Opcode 3 clears `running` at the next edge. From then on the control outputs are zero.
- R8: `stop` clears `running` at the next edge and takes priority over a simultaneous `start`. While stopped, the program counter holds.
- R9: A host write with `host_we`=1 while stopped stores `host_wdata` into the target given by `host_sel`: 0 is the instruction store, 1 the crossbar bank, 2 the memory bank, 3 the processing-unit bank. Writes made while running are ignored.
- R10: A `start` pulse while running restarts execution at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 |
| stop | input | 1 | End execution |
| flags | input | 4 | Status flags for conditional jumps |
| host_we | input | 1 | Host write enable |
| host_sel | input | 2 | Host write target: instruction store or one of the banks |
| host_addr | input | 6 | Host write address; banks use the low 4 bits |
| host_wdata | input | 40 | Host write data, low bits used for narrower targets |
| xbar_ctrl | output | 40 | Crossbar routing control word |
| mem_ctrl | output | 24 | Memory access control word |
| pu_ctrl | output | 32 | Processing-unit control word |
| running | output | 1 | Execution in progress |

## Verification
The hardest case to reach from the ports is a host write that lands while the program is running. Proving that it was dropped needs the program to be stopped and restarted, so that the entry it aimed at is fetched again. The stimulus writes a bank entry during a run and then restarts mid-program, which also covers R10. It then stops, restarts, and compares the control word of the instruction that indexes that entry. A second hard case is proving that conditional jumps ignore the unselected flags. For this, the stimulus table drives every other flag to 1 while the selected flag is 0, and checks that the program counter still only increments.

// File: rtl/cfg_seq.sv
module cfg_seq #(
  parameter int PC_W  = 6,
  parameter int IDX_W = 4,
  parameter int XW    = 40,
  parameter int MW    = 24,
  parameter int PW    = 32,
  parameter int NFLAG = 4,
  localparam int FS_W = $clog2(NFLAG),
  localparam int OP_W = 2,
  localparam int IW   = OP_W + FS_W + PC_W + 3 * IDX_W,
  localparam int HW0  = (XW > MW) ? XW : MW,
  localparam int HW1  = (HW0 > PW) ? HW0 : PW,
  localparam int HW   = (HW1 > IW) ? HW1 : IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [NFLAG-1:0] flags,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [PC_W-1:0]  host_addr,
  input  logic [HW-1:0]    host_wdata,
  output logic [XW-1:0]    xbar_ctrl,
  output logic [MW-1:0]    mem_ctrl,
  output logic [PW-1:0]    pu_ctrl,
  output logic             running
);
  localparam int IDEPTH = 1 << PC_W;
  localparam int CDEPTH = 1 << IDX_W;

  localparam logic [OP_W-1:0] OP_NEXT = 2'd0;
  localparam logic [OP_W-1:0] OP_JMP  = 2'd1;
  localparam logic [OP_W-1:0] OP_JC   = 2'd2;
  localparam logic [OP_W-1:0] OP_HALT = 2'd3;

  logic [IW-1:0] imem  [IDEPTH];
  logic [XW-1:0] xbank [CDEPTH];
  logic [MW-1:0] mbank [CDEPTH];
  logic [PW-1:0] pbank [CDEPTH];

  logic [PC_W-1:0] pc;
  logic [IW-1:0]   ins;
  logic [IDX_W-1:0] xi, mi, pi;
  logic [PC_W-1:0] tgt;
  logic [FS_W-1:0] fs;
  logic [OP_W-1:0] op;
  logic [PC_W-1:0] pc_inc;

  assign ins    = imem[pc];
  assign xi     = ins[0 +: IDX_W];
  assign mi     = ins[IDX_W +: IDX_W];
  assign pi     = ins[2*IDX_W +: IDX_W];
  assign tgt    = ins[3*IDX_W +: PC_W];
  assign fs     = ins[3*IDX_W+PC_W +: FS_W];
  assign op     = ins[IW-1 -: OP_W];
  assign pc_inc = pc + 1'b1;

  assign xbar_ctrl = running ? xbank[xi] : '0;
  assign mem_ctrl  = running ? mbank[mi] : '0;
  assign pu_ctrl   = running ? pbank[pi] : '0;

  always_ff @(posedge clk) begin
    if (host_we && !running) begin
      case (host_sel)
        2'd0: imem[host_addr] <= host_wdata[IW-1:0];
        2'd1: xbank[host_addr[IDX_W-1:0]] <= host_wdata[XW-1:0];
        2'd2: mbank[host_addr[IDX_W-1:0]] <= host_wdata[MW-1:0];
        default: pbank[host_addr[IDX_W-1:0]] <= host_wdata[PW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
    end else if (stop) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      pc      <= '0;
    end else if (running) begin
      case (op)
        OP_NEXT: pc <= pc_inc;
        OP_JMP:  pc <= tgt;
        OP_JC:   pc <= flags[fs] ? tgt : pc_inc;
        default: running <= 1'b0;
      endcase
    end
  end

  logic advance;
  assign advance = running && !start && !stop;

  assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (running && pc == '0));
  assert_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && op == OP_NEXT) |=> (pc == PC_W'($past(pc) + 1'b1)));
  assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && op == OP_JMP) |=> (pc == $past(tgt) && running));
  assert_cond_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && op == OP_JC && !flags[fs]) |=> (pc == PC_W'($past(pc) + 1'b1)));
  assert_cond_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && op == OP_JC && flags[fs]) |=> (pc == $past(tgt)));
  assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && op == OP_HALT) |=> !running);
  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(pc));
endmodule

// File: tb/cfg_seq_tb.sv
module cfg_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [3:0]  flags = '0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = '0;
  logic [5:0]  host_addr = '0;
  logic [39:0] host_wdata = '0;
  logic [39:0] xbar_ctrl;
  logic [23:0] mem_ctrl;
  logic [31:0] pu_ctrl;
  logic        running;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .flags(flags),
    .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .xbar_ctrl(xbar_ctrl), .mem_ctrl(mem_ctrl),
    .pu_ctrl(pu_ctrl), .running(running)
  );

  function automatic logic [39:0] xv(int i);
    return 40'h10_0000_0000 + 40'(i) * 40'h0101_0101;
  endfunction
  function automatic logic [23:0] mv(int i);
    return 24'h20_0000 + 24'(i) * 24'h0111;
  endfunction
  function automatic logic [31:0] pv(int i);
    return 32'h3000_0000 + 32'(i) * 32'h0010_1001;
  endfunction

  function automatic logic [21:0] prog(int a);
    logic [1:0] op = 2'd0;
    logic [5:0] t = 6'd0;
    logic [1:0] fsel = 2'd0;
    case (a)
      2:  begin op = 2'd1; t = 6'd10; end
      10: begin op = 2'd2; fsel = 2'd1; t = 6'd20; end
      12: begin op = 2'd2; fsel = 2'd0; t = 6'd5; end
      5:  begin op = 2'd1; t = 6'd62; end
      20: begin op = 2'd1; t = 6'd40; end
      40: op = 2'd3;
      default: ;
    endcase
    return {op, fsel, t, 4'(~a), 4'(a + 5), 4'(a)};
  endfunction

  function automatic logic [95:0] exp_ctrl(int a);
    return {xv(a & 15), mv((a + 5) & 15), pv((~a) & 15)};
  endfunction

  // {flags, expected pc, expected running}
  localparam logic [10:0] VEC [16] = '{
    {4'h0, 6'd0,  1'b1}, {4'h0, 6'd1,  1'b1}, {4'h0, 6'd2,  1'b1},
    {4'hD, 6'd10, 1'b1}, {4'h0, 6'd11, 1'b1}, {4'h1, 6'd12, 1'b1},
    {4'h0, 6'd5,  1'b1}, {4'h0, 6'd62, 1'b1}, {4'h0, 6'd63, 1'b1},
    {4'h0, 6'd0,  1'b1}, {4'h0, 6'd1,  1'b1}, {4'h0, 6'd2,  1'b1},
    {4'h2, 6'd10, 1'b1}, {4'h0, 6'd20, 1'b1}, {4'h0, 6'd40, 1'b1},
    {4'h0, 6'd0,  1'b0}
  };

  task automatic check(string req, logic [95:0] act, logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [1:0] sel, int addr, logic [39:0] data);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_addr = 6'(addr); host_wdata = data;
    @(posedge clk);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 running", 96'(running), 96'(0));
    check("R1 ctrl", {xbar_ctrl, mem_ctrl, pu_ctrl}, 96'(0));
    rst_n = 1'b1;

    for (int a = 0; a < 64; a++) host_write(2'd0, a, 40'(prog(a)));
    for (int i = 0; i < 16; i++) begin
      host_write(2'd1, i, xv(i));
      host_write(2'd2, i, 40'(mv(i)));
      host_write(2'd3, i, 40'(pv(i)));
    end

    // R2 R3 R4 R5 R6 R7 walked by the vector table
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      start = 1'b0;
      flags = VEC[c][10:7];
      #1;
      check($sformatf("R2-seq step %0d running", c), 96'(running), 96'(VEC[c][0]));
      check($sformatf("R3 step %0d ctrl", c), {xbar_ctrl, mem_ctrl, pu_ctrl},
            VEC[c][0] ? exp_ctrl(int'(VEC[c][6:1])) : 96'(0));
      @(posedge clk);
    end
    flags = '0;

    // R8: stop wins over simultaneous start
    @(negedge clk);
    start = 1'b1; stop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    #1;
    check("R8 stop priority", 96'(running), 96'(0));
    check("R8 idle ctrl", {xbar_ctrl, mem_ctrl, pu_ctrl}, 96'(0));

    // R9: write while stopped takes effect
    host_write(2'd1, 0, 40'hAB_CDEF_1234);
    pulse_start();
    check("R9 stopped write", 96'(xbar_ctrl), 96'(40'hAB_CDEF_1234));

    // R9: write while running is ignored
    host_write(2'd1, 1, 40'hBA_DBAD_BAD0);

    // R10: restart while running
    pulse_start();
    check("R10 restart pc0", {xbar_ctrl, mem_ctrl, pu_ctrl},
          {40'hAB_CDEF_1234, mv(5), pv(15)});

    // R8: stop ends execution
    @(negedge clk);
    stop = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop = 1'b0;
    #1;
    check("R8 stop", 96'(running), 96'(0));
    check("R8 stop ctrl", {xbar_ctrl, mem_ctrl, pu_ctrl}, 96'(0));

    host_write(2'd1, 0, xv(0));
    pulse_start();
    check("R9 restored pc0", {xbar_ctrl, mem_ctrl, pu_ctrl}, exp_ctrl(0));
    step();
    check("R9 running write ignored", 96'(xbar_ctrl), 96'(xv(1)));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule